// File: doc/BRIEF.md
# Two-Wire Configuration Target with Staged Commit

This block is a serial two-wire (I2C) target that runs in the system clock domain. It oversamples SCL and SDA, so it serves standard-mode (100 kHz) and fast-mode (400 kHz) masters when the system clock is comfortably faster than the bus. It holds a small configuration map that a master programs through the usual sequence. For a write, the master sends the device address with the write bit, a word address and one or more data bytes. For a read, it sends the device address and word address, then a repeated START with the read bit, and ends with a NACK and a STOP. The word pointer advances after each byte but stays inside its 16-byte page.

Four of the locations drive the synthesizer's loop settings and are staged. A bus write updates only a shadow byte. Writing the key value to the commit location copies all staged bytes to their live outputs at once and emits a single-cycle PLL reset strobe. The remaining read/write locations drive their outputs directly. Two read-only locations return a revision constant and the loop's lock flag. The low bit of the device address comes from a strap pin, so two targets can sit on one bus.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target acknowledges only the 7-bit device address {010011, addr_sel_i}; addr_sel_i supplies the least significant address bit.
- R2: Any other device address gets no acknowledge (SDA is left released during the ninth clock), and the target ignores the bus until the next START.
- R3: After a write header, the first data byte sets the word pointer. Each later byte is stored at the pointer, and the pointer then advances. Locations 00h–07h are read/write. Location 03h keeps only bits 3:0 and reads 0 in bits 7:4, and 04h always reads 00h.
- R4: The pointer advances only in its low four bits. It wraps from xFh to x0h of the same page, for both writes and reads.
- R5: A read after a repeated START returns the byte at the pointer MSB first. Each master ACK fetches the next location, and a master NACK ends the transfer.
- R6: Location 11h reads 01h. Location 12h reads {6'b0, lock_i, 1'b0}, and 10h reads 00h.
- R7: Locations 01h, 02h, 03h and 05h are staged: writes to them leave loop_ctrl_o, fb_div_o and trig_ctrl_o unchanged. Writing 5Ah to 08h copies all four shadows to those outputs (fb_div_o = {03h[3:0], 02h}) and raises pll_rst_o for exactly one clock.
- R8: Writing any value other than 5Ah to 08h changes no output and raises no strobe.
- R9: After reset, location 00h = 41h, 05h = 01h, and every other location and output is 0. in_ctrl_o, out_en_o and ref_div_o follow locations 00h, 06h and 07h directly.
- R10: Location 08h reads 00h. Writes to 10h–1Fh are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 1 | Strap for device address bit 0 |
| lock_i | input | 1 | Loop lock flag (1 = locked) |
| in_ctrl_o | output | 8 | Live value of location 00h |
| loop_ctrl_o | output | 8 | Committed value of location 01h |
| fb_div_o | output | 12 | Committed feedback divider word |
| trig_ctrl_o | output | 8 | Committed value of location 05h |
| out_en_o | output | 8 | Live value of location 06h |
| ref_div_o | output | 8 | Live value of location 07h |
| pll_rst_o | output | 1 | One-cycle strobe on commit |

## Verification
Each bus input passes through two synchronizer flops and one edge-detect register before the target sees it. Its acknowledge and data-bit drive therefore change about three clocks after an SCL fall. The bench sets SDA a quarter bit after each SCL fall and samples SDA at the middle of the SCL high phase, well clear of that latency. The write and commit results land one clock after the SCL fall that ends the ACK of the data byte. So the bench checks the direct outputs, the staged outputs and the strobe counter only after the STOP, which follows that fall by at least a quarter bit. The pulse monitor checks strobe width on every clock edge.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_st_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_WADDR,
        K_WDATA
    } rx_kind_e;
endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_o
);
    typedef struct packed {
        logic [STAGES:0] scl;
        logic [STAGES:0] sda;
    } sync_t;

    sync_t q, n;
    logic scl_cur, scl_prv, sda_cur, sda_prv;

    always_comb begin
        n     = q;
        n.scl = {q.scl[STAGES-1:0], scl_i};
        n.sda = {q.sda[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scl: '1, sda: '1};
        else        q <= n;
    end

    assign scl_cur    = q.scl[STAGES-1];
    assign scl_prv    = q.scl[STAGES];
    assign sda_cur    = q.sda[STAGES-1];
    assign sda_prv    = q.sda[STAGES];
    assign scl_rise_o = scl_cur & ~scl_prv;
    assign scl_fall_o = ~scl_cur & scl_prv;
    assign start_o    = scl_cur & scl_prv & sda_prv & ~sda_cur;
    assign stop_o     = scl_cur & scl_prv & ~sda_prv & sda_cur;
    assign sda_o      = sda_cur;
endmodule

// File: rtl/i2c_cfg_link.sv
module i2c_cfg_link
    import i2c_cfg_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b010011,
    parameter int AW = 8,
    parameter int PB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          sda_i,
    input  logic          addr_sel_i,
    input  logic [7:0]    rd_data_i,
    output logic          sda_oe_o,
    output logic          wr_en_o,
    output logic [AW-1:0] ptr_o,
    output logic [7:0]    wr_data_o
);
    typedef struct packed {
        bus_st_e       st;
        rx_kind_e      kind;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic [7:0]    tx;
        logic [AW-1:0] ptr;
        logic          rw;
    } link_t;

    link_t q, n;
    logic [6:0]    dev_addr;
    logic [AW-1:0] next_ptr;

    assign dev_addr = {ADDR_HI, addr_sel_i};
    assign next_ptr = {q.ptr[AW-1:PB], PB'(q.ptr[PB-1:0] + 1'b1)};

    always_comb begin
        n       = q;
        wr_en_o = 1'b0;
        if (stop_i) begin
            n.st = ST_IDLE;
        end else if (start_i) begin
            n.st   = ST_RX;
            n.kind = K_DEV;
            n.cnt  = '0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise_i && q.cnt != 4'd8) begin
                        n.sh  = {q.sh[6:0], sda_i};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == 4'd8) begin
                        if (q.kind != K_DEV) begin
                            n.st = ST_ACK;
                        end else if (q.sh[7:1] == dev_addr) begin
                            n.rw = q.sh[0];
                            n.st = ST_ACK;
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        n.cnt = '0;
                        if (q.kind == K_DEV && q.rw) begin
                            n.tx  = rd_data_i;
                            n.ptr = next_ptr;
                            n.st  = ST_TX;
                        end else begin
                            n.st = ST_RX;
                            if (q.kind == K_WADDR) n.ptr = q.sh[AW-1:0];
                            if (q.kind == K_WDATA) begin
                                wr_en_o = 1'b1;
                                n.ptr   = next_ptr;
                            end
                            n.kind = (q.kind == K_DEV) ? K_WADDR : K_WDATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (q.cnt == 4'd7) begin
                            n.st = ST_MACK;
                        end else begin
                            n.tx  = {q.tx[6:0], 1'b0};
                            n.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        n.sh[0] = sda_i;
                    end else if (scl_fall_i) begin
                        if (!q.sh[0]) begin
                            n.tx  = rd_data_i;
                            n.ptr = next_ptr;
                            n.cnt = '0;
                            n.st  = ST_TX;
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, kind: K_DEV, default: '0};
        else        q <= n;
    end

    assign sda_oe_o  = (q.st == ST_ACK) | (q.st == ST_TX & ~q.tx[7]);
    assign ptr_o     = q.ptr;
    assign wr_data_o = q.sh;

    // R2: an idle target never holds the data line
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !sda_oe_o);

    // R2: a foreign device address is answered with a released line
    p_foreign_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RX && q.kind == K_DEV && scl_fall_i && q.cnt == 4'd8 &&
         !start_i && !stop_i && q.sh[7:1] != dev_addr) |=> !sda_oe_o);

    // R4: the page part of the pointer moves only on a word-address load
    p_page_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.st == ST_ACK && q.kind == K_WADDR) |=> $stable(q.ptr[AW-1:PB]));

    // R3: a received byte never exceeds eight bits
    p_bit_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= 4'd8);
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs #(
    parameter int         NREG        = 8,
    parameter logic [7:0] KEY         = 8'h5A,
    parameter logic [7:0] COMMIT_ADDR = 8'h08,
    parameter logic [7:0] REV_ADDR    = 8'h11,
    parameter logic [7:0] STAT_ADDR   = 8'h12,
    parameter logic [7:0] REV         = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [7:0]           addr_i,
    input  logic [7:0]           data_i,
    input  logic                 lock_i,
    output logic [7:0]           rd_data_o,
    output logic [NREG-1:0][7:0] view_o,
    output logic                 strobe_o
);
    localparam int IW = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][7:0] sh;
        logic [NREG-1:0][7:0] act;
        logic                 strobe;
    } regs_t;

    regs_t q, n;

    function automatic logic is_staged(int i);
        return (i == 1) || (i == 2) || (i == 3) || (i == 5);
    endfunction

    function automatic logic [7:0] wmask(int i);
        if (i == 3) return 8'h0F;
        if (i == 4) return 8'h00;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] rst_val(int i);
        if (i == 0) return 8'h41;
        if (i == 5) return 8'h01;
        return 8'h00;
    endfunction

    logic in_map;
    assign in_map = (addr_i < 8'(NREG));

    always_comb begin
        n        = q;
        n.strobe = 1'b0;
        if (wr_en_i) begin
            if (in_map)
                n.sh[addr_i[IW-1:0]] = data_i & wmask(int'(addr_i[IW-1:0]));
            if (addr_i == COMMIT_ADDR && data_i == KEY) begin
                for (int i = 0; i < NREG; i++)
                    if (is_staged(i)) n.act[i] = q.sh[i];
                n.strobe = 1'b1;
            end
        end
    end

    always_comb begin
        if (in_map)                 rd_data_o = q.sh[addr_i[IW-1:0]];
        else if (addr_i == REV_ADDR)  rd_data_o = REV;
        else if (addr_i == STAT_ADDR) rd_data_o = {6'b0, lock_i, 1'b0};
        else                          rd_data_o = 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                q.sh[i]  <= rst_val(i);
                q.act[i] <= rst_val(i);
            end
            q.strobe <= 1'b0;
        end else begin
            q <= n;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_view
        if (is_staged(g)) begin : g_staged
            assign view_o[g] = q.act[g];
        end else begin : g_direct
            assign view_o[g] = q.sh[g];
        end
    end

    assign strobe_o = q.strobe;

    // R7: the reset strobe lasts one clock
    p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.strobe |=> !q.strobe);

    // R7: on the strobe the live divider matches its shadow
    p_commit_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.strobe |-> (q.act[2] == q.sh[2]) && (q.act[3] == q.sh[3]));

    // R8: live staged bytes move only together with the strobe
    p_live_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.strobe |-> $stable(q.act));
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
    parameter logic [5:0] ADDR_HI = 6'b010011,
    parameter logic [7:0] KEY     = 8'h5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic        addr_sel_i,
    input  logic        lock_i,
    output logic [7:0]  in_ctrl_o,
    output logic [7:0]  loop_ctrl_o,
    output logic [11:0] fb_div_o,
    output logic [7:0]  trig_ctrl_o,
    output logic [7:0]  out_en_o,
    output logic [7:0]  ref_div_o,
    output logic        pll_rst_o
);
    localparam int NREG = 8;

    logic scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic wr_en;
    logic [7:0] ptr, wr_data, rd_data;
    logic [NREG-1:0][7:0] view;
    logic unused_bits;

    i2c_cfg_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_det), .stop_o(stop_det), .sda_o(sda_s)
    );

    i2c_cfg_link #(.ADDR_HI(ADDR_HI), .AW(8), .PB(4)) link_i (
        .clk(clk), .rst_n(rst_n),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_det), .stop_i(stop_det), .sda_i(sda_s),
        .addr_sel_i(addr_sel_i), .rd_data_i(rd_data),
        .sda_oe_o(sda_oe_o), .wr_en_o(wr_en), .ptr_o(ptr), .wr_data_o(wr_data)
    );

    i2c_cfg_regs #(.NREG(NREG), .KEY(KEY)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(ptr),
        .data_i(wr_data), .lock_i(lock_i), .rd_data_o(rd_data),
        .view_o(view), .strobe_o(pll_rst_o)
    );

    assign in_ctrl_o   = view[0];
    assign loop_ctrl_o = view[1];
    assign fb_div_o    = {view[3][3:0], view[2]};
    assign trig_ctrl_o = view[5];
    assign out_en_o    = view[6];
    assign ref_div_o   = view[7];
    assign unused_bits = ^{view[4], view[3][7:4]};
endmodule

// File: tb/i2c_cfg_target_tb_top.sv
module i2c_cfg_target_tb_top;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic addr_sel = 1'b0, lock = 1'b0;
    logic sda_oe, sda_bus, pll_rst;
    logic [7:0]  in_ctrl, loop_ctrl, trig_ctrl, out_en, ref_div;
    logic [11:0] fb_div;

    int checks = 0, errors = 0, pulses = 0, wide = 0;
    logic prev_rst = 1'b0;
    logic [6:0] dev;
    logic [7:0] rbuf [0:15];
    logic [7:0] wbuf [0:15];

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_cfg_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .lock_i(lock),
        .in_ctrl_o(in_ctrl), .loop_ctrl_o(loop_ctrl), .fb_div_o(fb_div),
        .trig_ctrl_o(trig_ctrl), .out_en_o(out_en), .ref_div_o(ref_div),
        .pll_rst_o(pll_rst)
    );

    always @(posedge clk) begin
        if (pll_rst) pulses++;
        if (pll_rst && prev_rst) wide++;
        prev_rst <= pll_rst;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); d[i] = sda_bus; wq(); scl_m = 1'b0;
        end
        wq(); sda_m = ~ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic wr(input logic [7:0] addr, input int n);
        logic a;
        bus_start();
        send_byte({dev, 1'b0}, a);
        send_byte(addr, a);
        for (int i = 0; i < n; i++) send_byte(wbuf[i], a);
        bus_stop();
        wq();
    endtask

    task automatic rd(input logic [7:0] addr, input int n);
        logic a;
        bus_start();
        send_byte({dev, 1'b0}, a);
        send_byte(addr, a);
        bus_start();
        send_byte({dev, 1'b1}, a);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
        bus_stop();
        wq();
    endtask

    task automatic probe(input logic [6:0] a, output logic ack);
        bus_start();
        send_byte({a, 1'b0}, ack);
        bus_stop();
        wq();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        int base;
        dev = 7'h26;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wq();

        // R9: reset state at the ports
        chk("R9 in_ctrl", in_ctrl, 16'h41);
        chk("R9 trig_ctrl", trig_ctrl, 16'h01);
        chk("R9 loop_ctrl", loop_ctrl, 0);
        chk("R9 fb_div", fb_div, 0);
        chk("R9 out_en", out_en, 0);
        chk("R9 ref_div", ref_div, 0);
        chk("R9 strobe", pll_rst, 0);
        chk("R9 sda", sda_oe, 0);

        // R5 R9: multi-byte read of reset contents
        rd(8'h00, 8);
        for (int i = 0; i < 8; i++)
            chk("R5 R9 reset read", rbuf[i], (i == 0) ? 16'h41 : (i == 5) ? 16'h01 : 16'h00);

        // R1 R2: sweep of every device address, strap low
        for (int a = 0; a < 128; a++) begin
            probe(7'(a), ack);
            chk((a == 8'h26) ? "R1 match ack" : "R2 foreign nack", ack, (a == 8'h26));
        end

        // R3 R7: write 00h..07h, direct bytes update, staged ones hold
        for (int i = 0; i < 8; i++) wbuf[i] = 8'((8'h11 * i) + 8'h03);
        base = pulses;
        wr(8'h00, 8);
        chk("R3 in_ctrl direct", in_ctrl, 16'h03);
        chk("R3 out_en direct", out_en, 16'h69);
        chk("R3 ref_div direct", ref_div, 16'h7A);
        chk("R7 loop staged", loop_ctrl, 0);
        chk("R7 fb staged", fb_div, 0);
        chk("R7 trig staged", trig_ctrl, 16'h01);
        chk("R7 no strobe", pulses - base, 0);
        rd(8'h00, 8);
        for (int i = 0; i < 8; i++)
            chk("R3 readback", rbuf[i],
                (i == 4) ? 16'h00 : (i == 3) ? 16'(wbuf[i] & 8'h0F) : 16'(wbuf[i]));

        // R8 R10: wrong key, then read of the commit location
        wbuf[0] = 8'h33;
        wr(8'h08, 1);
        chk("R8 no strobe", pulses - base, 0);
        chk("R8 loop held", loop_ctrl, 0);
        chk("R8 fb held", fb_div, 0);
        rd(8'h08, 1);
        chk("R10 commit reads zero", rbuf[0], 0);

        // R7: key commit
        wbuf[0] = 8'h5A;
        wr(8'h08, 1);
        chk("R7 one strobe", pulses - base, 1);
        chk("R7 strobe width", wide, 0);
        chk("R7 loop live", loop_ctrl, 16'h14);
        chk("R7 fb live", fb_div, 16'h625);
        chk("R7 trig live", trig_ctrl, 16'h58);

        // R4: write wraps inside page 0
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
        wr(8'h0E, 4);
        chk("R4 wrap write in_ctrl", in_ctrl, 16'hA3);
        chk("R4 staged after wrap", loop_ctrl, 16'h14);
        rd(8'h0F, 3);
        chk("R4 read 0F", rbuf[0], 0);
        chk("R4 read wraps to 00", rbuf[1], 16'hA3);
        chk("R4 read wraps to 01", rbuf[2], 16'hA4);
        rd(8'h1F, 2);
        chk("R4 page1 1F", rbuf[0], 0);
        chk("R4 page1 wraps to 10", rbuf[1], 0);

        // R6: read-only status
        lock = 1'b0;
        rd(8'h10, 3);
        chk("R6 10h", rbuf[0], 0);
        chk("R6 rev", rbuf[1], 16'h01);
        chk("R6 unlocked", rbuf[2], 0);
        lock = 1'b1;
        rd(8'h12, 1);
        chk("R6 locked", rbuf[0], 16'h02);

        // R10: writes to the upper page are dropped
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
        wr(8'h11, 2);
        rd(8'h11, 2);
        chk("R10 rev kept", rbuf[0], 16'h01);
        chk("R10 status kept", rbuf[1], 16'h02);

        // R1: strap high moves the address
        addr_sel = 1'b1;
        probe(7'h27, ack);
        chk("R1 strap high ack", ack, 1);
        probe(7'h26, ack);
        chk("R2 strap high old nack", ack, 0);
        dev = 7'h27;
        rd(8'h07, 1);
        chk("R1 strap high read", rbuf[0], 16'h7A);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule